// File: doc/BRIEF.md
# Four-Lane Phase-Staggered Sine/Cosine Synthesizer

This block produces sine and cosine samples in four parallel lanes. All lanes step through phase by the same increment each clock. Each lane starts from its own fixed phase offset, and the offsets are multiples of a per-lane step. If the step is a quarter of the increment, the lanes fill in the points between one clock's sample and the next. A downstream serializer that sends lane 0, then lane 1, lane 2 and lane 3 inside each clock period then yields one tone sampled at four times the clock rate.

One start pulse copies the increment and the derived per-lane offsets into the lanes and starts generation. After that, the configuration inputs and further start pulses have no effect until reset. Each lane keeps a 30-bit phase accumulator. The top ten bits of accumulator plus offset address a quarter-wave magnitude table, and quadrant folding rebuilds the full period from that quarter. The four 32-bit lane words leave on one 128-bit bus under a single valid flag.

Top module: `multilane_dds`

## Requirements
- R1: While reset is asserted, and after reset until the first start, `cfg_valid_o` and `dout_valid_o` are 0 and `dout_o` is all zeros.
- R2: A start pulse while idle sets `cfg_valid_o` at the next clock edge. It then stays 1 until reset.
- R3: `dout_valid_o` rises exactly two clocks after `cfg_valid_o` rises and then stays 1. One flag covers all four lanes.
- R4: Output sample n (n = 0 for the first valid cycle, then +1 per clock) of lane k (k = 0..3) uses phase p = (n*inc + k*step) mod 2^30. Lane 0 therefore has no offset.
- R5: `inc_i` and `step_i` are captured only at the accepted start. Later start pulses and changes to `inc_i` or `step_i` do not alter the output sequence until reset.
- R6: Lane k occupies `dout_o[32k+31:32k]`, with signed sine in the upper 16 bits and signed cosine in the lower 16 bits. Lane 0 is in the least significant word and is the first in serial order.
- R7: With a = p[29:20], sine equals round(32767*sin(2*pi*(a+0.5)/1024)) within 1 LSB. Cosine is the same function at (a+256) mod 1024. The value -32768 never appears.
- R8: Bits 31:30 of `inc_i` and `step_i` have no effect on any output.
- R9: With a zero increment, every lane holds a constant value set only by its own offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Captures the configuration and starts generation when idle |
| inc_i | input | 32 | Phase increment shared by all lanes |
| step_i | input | 32 | Phase offset step between neighbouring lanes |
| cfg_valid_o | output | 1 | Configuration captured, generation running |
| dout_valid_o | output | 1 | `dout_o` holds valid samples |
| dout_o | output | 128 | Four lane words, lane 0 in bits 31:0 |

## Verification
The bench sweeps an increment of exactly one table address per clock with quarter-turn lane offsets. Every one of the 1024 addresses then passes through every lane, so a wrong quadrant fold shows up as a sign flip or a mirrored ramp in one quarter of the period. A bench that checked only a few points would miss it. Counting the first valid sample from the exact latency catches a pipeline that is one stage off, because every lane would then appear shifted by one increment. A second start pulse with new inputs is sent in the middle of a run; a design that reloads would jump to the new tone. Increments and steps with bits 31:30 set, and a zero increment, catch accumulators wider than 30 bits and lanes that are offset from the wrong reference.

// File: rtl/mdds_pkg.sv
`timescale 1ns/1ps
package mdds_pkg;
  localparam real PI = 3.14159265358979323846;

  // magnitude of quarter-wave entry idx, half-sample centred
  function automatic int quarter_mag(int idx, int depth, int dw);
    real amp;
    real ang;
    amp = real'((1 << (dw - 1)) - 1);
    ang = PI * (real'(idx) + 0.5) / (2.0 * real'(depth));
    return $rtoi(amp * $sin(ang) + 0.5);
  endfunction
endpackage

// File: rtl/mdds_cfg_pack.sv
`timescale 1ns/1ps
module mdds_cfg_pack #(
  parameter int LANES = 4,
  parameter int CW    = 32
) (
  input  logic [CW-1:0]   inc_i,
  input  logic [CW-1:0]   step_i,
  output logic [2*CW-1:0] word_o [LANES]
);
  // upper half offset, lower half increment
  for (genvar k = 0; k < LANES; k++) begin : g_word
    assign word_o[k] = {CW'(step_i * CW'(k)), inc_i};
  end
endmodule

// File: rtl/mdds_sincos.sv
`timescale 1ns/1ps
module mdds_sincos #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AW-1:0]        addr_i,
  output logic signed [DW-1:0] sin_o,
  output logic signed [DW-1:0] cos_o
);
  localparam int QW = AW - 2;
  localparam int QD = 1 << QW;

  logic [DW-2:0] qtab [QD];
  for (genvar g = 0; g < QD; g++) begin : g_tab
    assign qtab[g] = (DW-1)'(mdds_pkg::quarter_mag(g, QD, DW));
  end

  logic [AW-1:0]        addr_c;
  logic [QW-1:0]        idx_s, idx_c;
  logic signed [DW-1:0] mag_s, mag_c, sin_d, cos_d;

  assign addr_c = addr_i + AW'(QD);

  always_comb begin
    idx_s = addr_i[AW-2] ? ~addr_i[QW-1:0] : addr_i[QW-1:0];
    idx_c = addr_c[AW-2] ? ~addr_c[QW-1:0] : addr_c[QW-1:0];
    mag_s = signed'({1'b0, qtab[idx_s]});
    mag_c = signed'({1'b0, qtab[idx_c]});
    sin_d = addr_i[AW-1] ? -mag_s : mag_s;
    cos_d = addr_c[AW-1] ? -mag_c : mag_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_o <= '0;
      cos_o <= '0;
    end else begin
      sin_o <= sin_d;
      cos_o <= cos_d;
    end
  end

  // R7
  sincos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sin_o != {1'b1, {(DW-1){1'b0}}}) && (cos_o != {1'b1, {(DW-1){1'b0}}}));
endmodule

// File: rtl/mdds_lane.sv
`timescale 1ns/1ps
module mdds_lane #(
  parameter int CW = 32,
  parameter int PW = 30,
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 run_i,
  input  logic [2*CW-1:0]      cfg_i,
  output logic signed [DW-1:0] sin_o,
  output logic signed [DW-1:0] cos_o
);
  logic [CW-1:0] inc_q, off_q, acc_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_q <= '0;
      off_q <= '0;
      acc_q <= '0;
    end else if (load_i) begin
      inc_q <= cfg_i[CW-1:0];
      off_q <= cfg_i[2*CW-1:CW];
      acc_q <= '0;
    end else if (run_i) begin
      acc_q <= acc_q + inc_q;
    end
  end

  // only phase bits below PW reach the address, so wrap is mod 2^PW
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= AW'((acc_q + off_q) >> (PW - AW));
  end

  mdds_sincos #(.AW(AW), .DW(DW)) u_rom (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_q),
    .sin_o  (sin_o),
    .cos_o  (cos_o)
  );

  // R4
  acc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && !$past(load_i)) |-> (acc_q == $past(acc_q) + $past(inc_q)));
  // R4
  load_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i) |-> (acc_q == '0));
  // R5
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(inc_q) && $stable(off_q)));
endmodule

// File: rtl/multilane_dds.sv
`timescale 1ns/1ps
module multilane_dds #(
  parameter int LANES = 4,
  parameter int CW    = 32,
  parameter int PW    = 30,
  parameter int AW    = 10,
  parameter int DW    = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [CW-1:0]           inc_i,
  input  logic [CW-1:0]           step_i,
  output logic                    cfg_valid_o,
  output logic                    dout_valid_o,
  output logic [LANES*2*DW-1:0]   dout_o
);
  localparam int LAT = 2;
  localparam int LW  = 2 * DW;

  logic [2*CW-1:0]      cfg_w [LANES];
  logic signed [DW-1:0] sin_w [LANES];
  logic signed [DW-1:0] cos_w [LANES];
  logic [LANES*LW-1:0]  word_w;
  logic                 run_q, load;
  logic [LAT-1:0]       vld_q;

  assign load = start_i && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      vld_q <= '0;
    end else begin
      if (load) run_q <= 1'b1;
      vld_q <= {vld_q[LAT-2:0], run_q};
    end
  end

  mdds_cfg_pack #(.LANES(LANES), .CW(CW)) u_pack (
    .inc_i  (inc_i),
    .step_i (step_i),
    .word_o (cfg_w)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    mdds_lane #(.CW(CW), .PW(PW), .AW(AW), .DW(DW)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .run_i  (run_q),
      .cfg_i  (cfg_w[k]),
      .sin_o  (sin_w[k]),
      .cos_o  (cos_w[k])
    );
    assign word_w[k*LW +: LW] = {sin_w[k], cos_w[k]};
  end

  assign cfg_valid_o  = run_q;
  assign dout_valid_o = vld_q[LAT-1];
  assign dout_o       = dout_valid_o ? word_w : '0;

  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |=> cfg_valid_o);
  // R3
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_valid_o) |-> ##2 $rose(dout_valid_o));
  // R3
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_valid_o |=> dout_valid_o);
  // R3
  valid_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_valid_o |-> cfg_valid_o);
endmodule

// File: tb/multilane_dds_bench.sv
`timescale 1ns/1ps
module multilane_dds_bench;
  localparam real    PI   = 3.14159265358979323846;
  localparam longint MASK = 64'h3FFF_FFFF;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  inc = '0;
  logic [31:0]  step = '0;
  logic         cfg_valid, dout_valid;
  logic [127:0] dout;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  multilane_dds u_multilane_dds (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .inc_i        (inc),
    .step_i       (step),
    .cfg_valid_o  (cfg_valid),
    .dout_valid_o (dout_valid),
    .dout_o       (dout)
  );

  function automatic int ref_val(int a);
    real v;
    v = 32767.0 * $sin(2.0 * PI * (real'(a) + 0.5) / 1024.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R4 R6 R7: lane k of sample n
  task automatic check_lane(int k, int n, longint mi, longint ms, string req);
    longint p;
    int a, es, ec, as_, ac_;
    p   = (longint'(n) * mi + longint'(k) * ms) & MASK;
    a   = int'(p >> 20);
    es  = ref_val(a);
    ec  = ref_val((a + 256) % 1024);
    as_ = int'($signed(dout[32*k+16 +: 16]));
    ac_ = int'($signed(dout[32*k    +: 16]));
    check((as_ - es <= 1) && (es - as_ <= 1), req, $sformatf("lane%0d n%0d sin", k, n), as_, es);
    check((ac_ - ec <= 1) && (ec - ac_ <= 1), req, $sformatf("lane%0d n%0d cos", k, n), ac_, ec);
  endtask

  task automatic run_cfg(logic [31:0] ci, logic [31:0] cs, int ns, int glitch_at, string req);
    longint mi, ms;
    mi = longint'(ci) & MASK;
    ms = longint'(cs) & MASK;
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; inc = ci; step = cs;
    @(negedge clk);
    check(!cfg_valid && !dout_valid && dout == '0, "R1", "in reset", longint'(dout[63:0]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cfg_valid && !dout_valid && dout == '0, "R1", "idle", longint'(cfg_valid), 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cfg_valid, "R2", "cfg_valid after start", longint'(cfg_valid), 1);
    check(!dout_valid, "R3", "valid at +1", longint'(dout_valid), 0);
    @(negedge clk);
    check(!dout_valid, "R3", "valid at +2", longint'(dout_valid), 0);
    @(negedge clk);
    for (int n = 0; n < ns; n++) begin
      check(dout_valid && cfg_valid, "R3", "valid held", longint'(dout_valid), 1);
      for (int k = 0; k < 4; k++) check_lane(k, n, mi, ms, req);
      if (n == glitch_at) begin
        start = 1'b1; inc = ~ci; step = ci;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    // R7 R6 R4: one address per clock, quarter-turn lane spacing
    run_cfg(32'h0010_0000, 32'h1000_0000, 1024, -1, "R7");
    // R5: nominal tone, lanes interleaved, restart attempt mid-run
    run_cfg(32'd107374182, 32'd26843545, 300, 100, "R5");
    // R8: bits 31:30 set on both inputs
    run_cfg(32'hC0BC_614E, 32'h84A2_D1F1, 200, -1, "R8");
    // R9: zero increment, constant per-lane output
    run_cfg(32'h0000_0000, 32'h3FFF_FFFF, 20, 5, "R9");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R3 watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule